// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block takes the per-clock control pins of a 32-bit synchronous burst SRAM with four byte lanes and turns them into memory actions. Two address strobes start an access: one from a processor and one from a controller. Three chip selects qualify each start. Advance, global write, byte-write enable and four byte selects control the cycles that follow. The block owns a small byte-lane memory array, a two-bit burst address sequencer for the low address bits, a registered read-data stage and a drive enable for the shared data bus.

An access opens on a strobe and captures a base address. While both strobes are high, the following clocks either step the burst address or hold it, and the write controls sampled on that clock choose between read and write. Read data for an address sampled at one rising edge is on the output register after the next edge. The drive enable follows a set of masking rules after deselects and writes, and the output-enable pin acts on it without a clock.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: The chip counts as selected only when `sel1_ni`=0, `sel2_i`=1 and `sel3_ni`=0 at the clock edge where a strobe is recognised. Any other combination makes that clock a deselect: nothing is written, and `dq_oe_o` is 0 after that edge.
- R2: `proc_strb_ni` is ignored while `sel1_ni`=1. With `ctrl_strb_ni`=1 such a clock behaves as a continue or suspend cycle and does not start a new access.
- R3: A selected processor-strobe start is always a read of `addr_i`, and the write controls on that clock have no effect. A write controlled by the pins on a following clock with both strobes high lands at the burst address, which gives a two-clock write.
- R4: A selected controller-strobe start (processor strobe high or ignored) with a write request writes `wdata_i` at `addr_i` on that same clock.
- R5: `gwr_ni`=0 writes all four lanes, whatever `bwe_ni` and `bsel_ni` are.
- R6: With `gwr_ni`=1, lane i (bits 8i+7:8i) is written only when `bwe_ni`=0 and `bsel_ni[i]`=0. Other lanes keep their contents. With no lane requested, the clock is a read.
- R7: A read whose address is sampled at edge k shows its data on `rdata_o`, with `dq_oe_o`=1 when `oe_ni`=0, after edge k+1.
- R8: `dq_oe_o` is 0 after any edge that performs a write, whatever `oe_ni` is. It stays 0 through continue-cycle reads until a read is started by a strobe.
- R9: On the first cycle of an access that follows a deselect, `dq_oe_o` is 0 even with `oe_ni`=0. Back-to-back strobe reads keep it at 1.
- R10: `oe_ni`=1 forces `dq_oe_o` to 0 without any clock edge, and returning it to 0 restores the drive.
- R11: With `linear_i`=1, burst step n from start low bits s accesses low bits (s+n) mod 4, for both reads and writes.
- R12: With `linear_i`=0, burst step n accesses low bits s XOR n.
- R13: When both strobes are high, `adv_ni`=1 repeats the current burst address and `adv_ni`=0 moves to the next one. The count wraps after four addresses.
- R14: While `rst_ni`=0, `dq_oe_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Access address, captured on a strobe |
| wdata_i | input | LANES*LANE_W | Write data |
| proc_strb_ni | input | 1 | Processor address strobe, active low |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| sel1_ni | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2_i | input | 1 | Chip select, active high |
| sel3_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwr_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | LANES | Per-lane byte selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench targets the clocks where the two strobes disagree. A processor start with write pins asserted would corrupt memory in a design that honours them. A processor strobe with `sel1_ni` high would restart the burst at `addr_i` if it were not ignored. The drive enable is checked on the cycle right after a deselect, after a write and across continue reads that follow a write; a wrong design would drive the bus there, or stay quiet on back-to-back reads. Every byte-select pattern and both burst orders from all four start offsets are swept, including suspend and wrap, so a wrong lane mapping or wrong sequence shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_PSTART,
    CYC_CSTART,
    CYC_CONT
  } cyc_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode import sram_ctrl_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic             proc_strb_ni,
  input  logic             ctrl_strb_ni,
  input  logic             sel1_ni,
  input  logic             sel2_i,
  input  logic             sel3_ni,
  input  logic             gwr_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bsel_ni,
  input  logic             active_i,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             rd_o
);
  logic             chip_on;
  logic             proc_seen;
  logic [LANES-1:0] req_lanes;

  assign chip_on   = !sel1_ni && sel2_i && !sel3_ni;
  assign proc_seen = !proc_strb_ni && !sel1_ni;

  always_comb begin
    if (!gwr_ni)      req_lanes = '1;
    else if (!bwe_ni) req_lanes = ~bsel_ni;
    else              req_lanes = '0;
  end

  always_comb begin
    if (proc_seen)          cyc_o = chip_on ? CYC_PSTART : CYC_DESEL;
    else if (!ctrl_strb_ni) cyc_o = chip_on ? CYC_CSTART : CYC_DESEL;
    else                    cyc_o = active_i ? CYC_CONT : CYC_NONE;
  end

  // processor starts never write; controller starts and bursts follow the pins
  always_comb begin
    lane_we_o = '0;
    rd_o      = 1'b0;
    case (cyc_o)
      CYC_PSTART: rd_o = 1'b1;
      CYC_CSTART, CYC_CONT: begin
        lane_we_o = req_lanes;
        rd_o      = (req_lanes == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic               step_i,
  input  logic               linear_i,
  output logic [BURST_W-1:0] cur_o,
  output logic [BURST_W-1:0] nxt_o
);
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_inc;

  function automatic logic [BURST_W-1:0] order(input logic [BURST_W-1:0] base,
                                               input logic [BURST_W-1:0] n,
                                               input logic lin);
    return lin ? base + n : base ^ n;
  endfunction

  assign cnt_inc = cnt_q + 1'b1;
  assign cur_o   = order(base_q, cnt_q, linear_i);
  assign nxt_o   = order(base_q, cnt_inc, linear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= start_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_inc;
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              drive_ok_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [ADDR_W-1:0] arr_raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drv_o
);
  logic [ADDR_W-1:0] raddr_q;
  logic              vld_q;

  assign arr_raddr_o = raddr_q;

  // stage 1: latch read address; stage 2: output register and drive flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raddr_q <= '0;
      vld_q   <= 1'b0;
      rdata_o <= '0;
      drv_o   <= 1'b0;
    end else begin
      if (issue_i) raddr_q <= addr_i;
      vld_q <= issue_i && drive_ok_i;
      if (vld_q) rdata_o <= arr_rdata_i;
      drv_o <= kill_i ? 1'b0 : vld_q;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl import sram_ctrl_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    proc_strb_ni,
  input  logic                    ctrl_strb_ni,
  input  logic                    sel1_ni,
  input  logic                    sel2_i,
  input  logic                    sel3_ni,
  input  logic                    adv_ni,
  input  logic                    gwr_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bsel_ni,
  input  logic                    oe_ni,
  input  logic                    linear_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  cyc_e               cyc;
  logic [LANES-1:0]   lane_we;
  logic               rd_req;
  logic               active_q;
  logic               hold_q;
  logic [HI_W-1:0]    hi_q;
  logic               is_start;
  logic               is_desel;
  logic               is_wr;
  logic               step;
  logic [BURST_W-1:0] cur_low;
  logic [BURST_W-1:0] nxt_low;
  logic [ADDR_W-1:0]  eff_addr;
  logic [ADDR_W-1:0]  arr_raddr;
  logic [DATA_W-1:0]  arr_rdata;
  logic               drv;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .sel1_ni      (sel1_ni),
    .sel2_i       (sel2_i),
    .sel3_ni      (sel3_ni),
    .gwr_ni       (gwr_ni),
    .bwe_ni       (bwe_ni),
    .bsel_ni      (bsel_ni),
    .active_i     (active_q),
    .cyc_o        (cyc),
    .lane_we_o    (lane_we),
    .rd_o         (rd_req)
  );

  assign is_start = (cyc == CYC_PSTART) || (cyc == CYC_CSTART);
  assign is_desel = (cyc == CYC_DESEL);
  assign is_wr    = |lane_we;
  assign step     = (cyc == CYC_CONT) && !adv_ni;

  sram_burst_seq #(.BURST_W(BURST_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (is_start),
    .start_i  (addr_i[BURST_W-1:0]),
    .step_i   (step),
    .linear_i (linear_i),
    .cur_o    (cur_low),
    .nxt_o    (nxt_low)
  );

  assign eff_addr = is_start ? addr_i : {hi_q, (step ? nxt_low : cur_low)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      hi_q     <= '0;
    end else begin
      if (is_desel)      active_q <= 1'b0;
      else if (is_start) active_q <= 1'b1;
      // bus stays quiet after a write until a strobe begins a read
      if (is_wr)         hold_q <= 1'b1;
      else if (is_start) hold_q <= 1'b0;
      if (is_start)      hi_q <= addr_i[ADDR_W-1:BURST_W];
    end
  end

  sram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .waddr_i (eff_addr),
    .wdata_i (wdata_i),
    .raddr_i (arr_raddr),
    .rdata_o (arr_rdata)
  );

  sram_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (rd_req),
    .drive_ok_i  (is_start || !hold_q),
    .kill_i      (is_desel || is_wr),
    .addr_i      (eff_addr),
    .arr_rdata_i (arr_rdata),
    .arr_raddr_o (arr_raddr),
    .rdata_o     (rdata_o),
    .drv_o       (drv)
  );

  assign dq_oe_o = drv && !oe_ni;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             proc_strb_ni,
  input logic             ctrl_strb_ni,
  input logic             sel1_ni,
  input logic             sel2_i,
  input logic             sel3_ni,
  input logic             gwr_ni,
  input logic             bwe_ni,
  input logic [LANES-1:0] bsel_ni,
  input logic             oe_ni,
  input logic             dq_oe_o
);
  logic chip_on, proc_seen, any_strb, desel, wr_any;
  logic pstart, cstart_wr, cstart_rd, cont_rd;

  assign chip_on   = !sel1_ni && sel2_i && !sel3_ni;
  assign proc_seen = !proc_strb_ni && !sel1_ni;
  assign any_strb  = proc_seen || !ctrl_strb_ni;
  assign desel     = any_strb && !chip_on;
  assign wr_any    = !gwr_ni || (!bwe_ni && !(&bsel_ni));
  assign pstart    = proc_seen && chip_on;
  assign cstart_wr = !proc_seen && !ctrl_strb_ni && chip_on && wr_any;
  assign cstart_rd = !proc_seen && !ctrl_strb_ni && chip_on && !wr_any;
  assign cont_rd   = proc_strb_ni && ctrl_strb_ni && !wr_any;

  p_desel_hiz_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |=> !dq_oe_o);

  p_pstart_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstart ##1 cont_rd |=> (oe_ni || dq_oe_o));

  p_write_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cstart_wr |=> !dq_oe_o);

  p_first_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel ##1 (pstart || cstart_rd) |=> !dq_oe_o);

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r14: assert (!dq_oe_o);
  end
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic        proc_n, ctrl_n, s1n, s2, s3n, adv_n, gw_n, bwe_n, oe_n, lin;
  logic [3:0]  bsel_n;
  logic [31:0] rdata;
  logic        dq_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] refm [64];

  always #2.5 clk = ~clk;

  sram_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .proc_strb_ni(proc_n), .ctrl_strb_ni(ctrl_n), .sel1_ni(s1n),
    .sel2_i(s2), .sel3_ni(s3n), .adv_ni(adv_n), .gwr_ni(gw_n),
    .bwe_ni(bwe_n), .bsel_ni(bsel_n), .oe_ni(oe_n), .linear_i(lin),
    .rdata_o(rdata), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fill(input int a);
    logic [7:0] x;
    x = a[7:0];
    return {x, ~x, x + 8'd60, x ^ 8'h5A};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic g, input logic b, input logic [3:0] m);
    logic [31:0] r;
    r = o;
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !m[i])) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  function automatic int bord(input int s, input int n, input logic l);
    return l ? ((s + n) & 3) : (s ^ n);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    proc_n = 1'b1; ctrl_n = 1'b1; s1n = 1'b0; s2 = 1'b1; s3n = 1'b0;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
  endtask

  task automatic desel();
    quiet(); ctrl_n = 1'b0; s1n = 1'b1;
    tick();
  endtask

  task automatic wr_c(input int a, input logic [31:0] d, input logic g,
                      input logic b, input logic [3:0] m);
    quiet(); ctrl_n = 1'b0; addr = a[5:0]; wdata = d; gw_n = g; bwe_n = b; bsel_n = m;
    tick();
    refm[a] = merge(refm[a], d, g, b, m);
  endtask

  task automatic rd_c(input int a);
    quiet(); ctrl_n = 1'b0; addr = a[5:0];
    tick();
  endtask

  // both strobes high; wa is the burst address the bench expects a write to hit
  task automatic cont(input logic adv, input logic g, input logic b,
                      input logic [3:0] m, input logic [31:0] d, input int wa);
    quiet(); adv_n = adv; gw_n = g; bwe_n = b; bsel_n = m; wdata = d;
    tick();
    if (wa >= 0) refm[wa] = merge(refm[wa], d, g, b, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; quiet(); oe_n = 1'b0; lin = 1'b1; addr = '0; wdata = '0;
    for (int i = 0; i < 64; i++) refm[i] = '0;
    repeat (3) tick();
    chk("R14 reset drive", {31'd0, dq_oe}, 32'd0);
    chk("R14 reset data", rdata, 32'd0);
    rst_n = 1'b1;
    tick();

    // fill with global writes (bwe high must not matter)
    for (int a = 0; a < 64; a++) begin
      wr_c(a, fill(a), 1'b0, 1'b1, 4'hF);
      if (a == 0) chk("R4 write bus quiet", {31'd0, dq_oe}, 32'd0);
    end
    rd_c(0);
    for (int a = 1; a < 64; a++) begin
      rd_c(a);
      chk("R7 read drive", {31'd0, dq_oe}, 32'd1);
      chk("R4 R5 read data", rdata, refm[a-1]);
    end
    desel();
    chk("R1 deselect drops drive", {31'd0, dq_oe}, 32'd0);

    // byte lanes: every select pattern, then bwe off, then global override
    for (int m = 0; m < 16; m++) wr_c(32 + m, ~fill(32 + m) ^ {8{m[3:0]}}, 1'b1, 1'b0, m[3:0]);
    wr_c(48, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
    wr_c(49, 32'h1357_9BDF, 1'b0, 1'b0, 4'hA);
    wr_c(50, 32'h2468_ACE0, 1'b0, 1'b1, 4'hF);
    rd_c(32);
    for (int a = 33; a < 52; a++) begin
      rd_c(a);
      if (a - 1 >= 49) chk("R5 global write data", rdata, refm[a-1]);
      else chk("R6 byte lane data", rdata, refm[a-1]);
    end
    desel();

    // processor start ignores write pins; write lands on the next clock
    quiet(); proc_n = 1'b0; addr = 6'd5; gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'h0;
    wdata = 32'h1111_2222;
    tick();
    cont(1'b1, 1'b1, 1'b1, 4'hF, 32'h0, -1);
    chk("R3 pstart read drive", {31'd0, dq_oe}, 32'd1);
    chk("R3 pstart no write", rdata, refm[5]);
    cont(1'b1, 1'b0, 1'b1, 4'hF, 32'h7788_99AA, 5);
    chk("R8 write after pstart quiet", {31'd0, dq_oe}, 32'd0);
    rd_c(5); rd_c(6);
    chk("R3 two-clock write data", rdata, refm[5]);
    desel();

    // processor strobe with sel1 high continues the burst
    rd_c(24);
    quiet(); proc_n = 1'b0; s1n = 1'b1; adv_n = 1'b0; addr = 6'd40;
    tick();
    chk("R2 ignored strobe drive", {31'd0, dq_oe}, 32'd1);
    chk("R2 ignored strobe data", rdata, refm[24]);
    tick();
    chk("R2 burst continued", rdata, refm[25]);
    desel();

    // each deselect variant blocks a write and drops the drive
    for (int v = 0; v < 4; v++) begin
      rd_c(10);
      quiet(); ctrl_n = 1'b0; gw_n = 1'b0; addr = 6'd8; wdata = 32'h0BAD_0BAD;
      case (v)
        0: s1n = 1'b1;
        1: s2 = 1'b0;
        2: s3n = 1'b1;
        default: begin proc_n = 1'b0; s2 = 1'b0; end
      endcase
      tick();
      chk("R1 deselect drive", {31'd0, dq_oe}, 32'd0);
      rd_c(8); rd_c(9);
      chk("R1 deselect no write", rdata, refm[8]);
    end

    // first cycle after deselect is masked, back-to-back reads are not
    desel();
    rd_c(3);
    chk("R9 first cycle masked", {31'd0, dq_oe}, 32'd0);
    rd_c(4);
    chk("R9 second cycle drive", {31'd0, dq_oe}, 32'd1);
    chk("R9 second cycle data", rdata, refm[3]);
    rd_c(5);
    chk("R9 back-to-back drive", {31'd0, dq_oe}, 32'd1);
    chk("R9 back-to-back data", rdata, refm[4]);

    // output enable acts without a clock
    oe_n = 1'b1; #1;
    chk("R10 oe high", {31'd0, dq_oe}, 32'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe low", {31'd0, dq_oe}, 32'd1);

    // after a write, continue reads stay quiet until a strobe read
    wr_c(12, 32'hA0B1_C2D3, 1'b0, 1'b1, 4'hF);
    cont(1'b0, 1'b1, 1'b1, 4'hF, 32'h0, -1);
    chk("R8 hold after write", {31'd0, dq_oe}, 32'd0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, 32'h0, -1);
    chk("R8 hold continues", {31'd0, dq_oe}, 32'd0);
    rd_c(12); rd_c(13);
    chk("R8 strobe read drives", {31'd0, dq_oe}, 32'd1);
    chk("R8 strobe read data", rdata, refm[12]);
    desel();

    // read bursts in both orders from all start offsets
    for (int l = 0; l < 2; l++) begin
      lin = l[0];
      for (int s = 0; s < 4; s++) begin
        rd_c(20 + s);
        for (int n = 1; n < 4; n++) begin
          cont(1'b0, 1'b1, 1'b1, 4'hF, 32'h0, -1);
          if (lin) chk("R11 linear step", rdata, refm[20 + bord(s, n - 1, lin)]);
          else     chk("R12 interleaved step", rdata, refm[20 + bord(s, n - 1, lin)]);
        end
        cont(1'b1, 1'b1, 1'b1, 4'hF, 32'h0, -1);
        chk(lin ? "R11 last step" : "R12 last step", rdata, refm[20 + bord(s, 3, lin)]);
        cont(1'b0, 1'b1, 1'b1, 4'hF, 32'h0, -1);
        chk("R13 suspend repeats", rdata, refm[20 + bord(s, 3, lin)]);
        cont(1'b1, 1'b1, 1'b1, 4'hF, 32'h0, -1);
        chk("R13 wrap to start", rdata, refm[20 + s]);
        desel();
      end
    end

    // linear write burst from offset 1
    lin = 1'b1;
    wr_c(41, 32'h0101_0101, 1'b0, 1'b1, 4'hF);
    cont(1'b0, 1'b0, 1'b1, 4'hF, 32'h0202_0202, 42);
    cont(1'b0, 1'b0, 1'b1, 4'hF, 32'h0303_0303, 43);
    cont(1'b0, 1'b0, 1'b1, 4'hF, 32'h0404_0404, 40);
    rd_c(40);
    for (int a = 41; a < 45; a++) begin
      rd_c(a);
      chk("R11 write burst data", rdata, refm[a-1]);
    end
    desel();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule